// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and a 32K x 8 asynchronous static RAM. The host presents a single request: a direction flag, a 15-bit word address and, for stores, an 8-bit value. The block then runs the memory pins through a fixed, cycle-counted sequence and returns a one-cycle completion pulse, along with the fetched byte for loads. Every analog timing figure of the memory, given in nanoseconds, is turned into a whole number of clock cycles from the clock-period parameter.

All memory-side controls are active low and registered. Between accesses the chip is deselected, so it stays in its low-power standby. A store keeps output enable high for the whole access. Write enable is pulsed strictly inside the chip-enable window. The data drivers come up before the strobe falls and stay up one cycle after it rises. When a load is followed by a store, extra idle cycles are inserted so that the memory's outputs have released the shared data lines before the controller drives them.

Top module: `asram_ctrl`

## Requirements
- R1: During and directly after reset, ce_n, oe_n and we_n are high (1), the data drivers are off, busy_o is low and done_o is low.
- R2: Whenever busy_o is low, ce_n, oe_n and we_n are all high and the data drivers are off.
- R3: A load holds ce_n and oe_n low with we_n high for RD_CYC = ceil(T_AA_NS/CLK_NS) cycles (2 at defaults). It captures sram_dq_i at the end of that window and returns it on rdata_o with done_o.
- R4: A store keeps oe_n high throughout. The data drivers and ce_n go active one cycle before we_n falls. we_n stays low for WR_CYC = max(ceil(T_PWE_NS/CLK_NS), ceil(T_SD_NS/CLK_NS)) cycles (1 at defaults), always inside the ce_n-low window.
- R5: we_n rises one cycle before ce_n rises and the drivers turn off. Address and driven data stay unchanged from the first driven cycle through that hold cycle.
- R6: The data drivers are never enabled while ce_n is low, oe_n is low and we_n is high.
- R7: A store that directly follows a load spends HZ_CYC = ceil(T_HZOE_NS/CLK_NS) extra cycles (1 at defaults) with all controls high before the drivers turn on.
- R8: Counted from the accepting edge, done_o rises after 3 cycles for a load and 4 for a store (5 for a store after a load). It is high for exactly one cycle.
- R9: req_i is ignored while busy_o is high. Such a request changes no memory location.
- R10: Address, direction and store data are latched at acceptance. Host inputs changing later do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request, accepted on an edge where busy_o is low |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 15 | Word address |
| req_wdata_i | input | 8 | Store data |
| busy_o | output | 1 | Access in progress; requests ignored |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Fetched byte, valid with done_o |
| sram_ce_n_o | output | 1 | Chip enable, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_addr_o | output | 15 | Memory address bus |
| sram_dq_o | output | 8 | Data toward memory |
| sram_dq_oe_o | output | 1 | Data driver enable |
| sram_dq_i | input | 8 | Data from memory |

## Verification
The assertions assume that the clock period really equals CLK_NS, since every cycle count derived from it is trusted. They also assume that the host drives req_i and its fields synchronously and never relies on a request made while busy_o is high. The stimulus drives all host inputs on falling edges only, using the same 8 ns period as the parameter. It deliberately toggles req_i and scrambles the address and data fields while an access is running, which exercises the ignore and latch behaviour without breaking those assumptions. The behavioural memory in the bench presents garbage until the address-to-data time has elapsed. It also reports short write strobes, missing data hold and driver overlap on its own.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WR_SET,
    ST_WR_PULSE,
    ST_WR_HOLD
  } seq_st_t;

  // ceiling division, never below one cycle
  function automatic int cyc_of(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)            cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          cap_i,
  input  logic          fin_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          done_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dout_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= fin_i;
      if (cap_i) dout_o <= din_i;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int CLK_NS    = 8,
  parameter int T_AA_NS   = 10,
  parameter int T_PWE_NS  = 7,
  parameter int T_SD_NS   = 5,
  parameter int T_HZOE_NS = 5
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          sram_ce_n_o,
  output logic          sram_oe_n_o,
  output logic          sram_we_n_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);
  localparam int RD_CYC = cyc_of(T_AA_NS, CLK_NS);
  localparam int WR_CYC = max2(cyc_of(T_PWE_NS, CLK_NS), cyc_of(T_SD_NS, CLK_NS));
  localparam int HZ_CYC = cyc_of(T_HZOE_NS, CLK_NS);
  localparam int MAXC   = max2(RD_CYC, max2(WR_CYC, HZ_CYC));
  localparam int CW     = $clog2(MAXC + 1) + 1;

  seq_st_t       state_q;
  logic          last_rd_q;
  logic          cnt_load, cnt_zero, cap, fin;
  logic [CW-1:0] cnt_val;

  asram_wait_cnt #(.CW(CW)) u_wait (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(cnt_load),
    .load_val_i(cnt_val), .zero_o(cnt_zero)
  );

  asram_rd_capture #(.DW(DW)) u_cap (
    .clk_i(clk_i), .rst_i(rst_i), .cap_i(cap), .fin_i(fin),
    .din_i(sram_dq_i), .dout_o(rdata_o), .done_o(done_o)
  );

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    cap      = 1'b0;
    fin      = 1'b0;
    case (state_q)
      ST_IDLE: if (req_i) begin
        cnt_load = 1'b1;
        if (!req_we_i)     cnt_val = CW'(RD_CYC - 1);
        else if (last_rd_q) cnt_val = CW'(HZ_CYC - 1);
      end
      ST_WR_SET: begin
        cnt_load = 1'b1;
        cnt_val  = CW'(WR_CYC - 1);
      end
      ST_RD:      if (cnt_zero) begin cap = 1'b1; fin = 1'b1; end
      ST_WR_HOLD: fin = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q      <= ST_IDLE;
      last_rd_q    <= 1'b0;
      sram_ce_n_o  <= 1'b1;
      sram_oe_n_o  <= 1'b1;
      sram_we_n_o  <= 1'b1;
      sram_addr_o  <= '0;
      sram_dq_o    <= '0;
      sram_dq_oe_o <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i) begin
          sram_addr_o <= req_addr_i;
          sram_dq_o   <= req_wdata_i;
          last_rd_q   <= !req_we_i;
          if (!req_we_i) begin
            state_q     <= ST_RD;
            sram_ce_n_o <= 1'b0;
            sram_oe_n_o <= 1'b0;
          end else if (last_rd_q) begin
            state_q <= ST_TURN;
          end else begin
            state_q      <= ST_WR_SET;
            sram_ce_n_o  <= 1'b0;
            sram_dq_oe_o <= 1'b1;
          end
        end
        ST_TURN: if (cnt_zero) begin
          state_q      <= ST_WR_SET;
          sram_ce_n_o  <= 1'b0;
          sram_dq_oe_o <= 1'b1;
        end
        ST_RD: if (cnt_zero) begin
          state_q     <= ST_IDLE;
          sram_ce_n_o <= 1'b1;
          sram_oe_n_o <= 1'b1;
        end
        ST_WR_SET: begin
          state_q     <= ST_WR_PULSE;
          sram_we_n_o <= 1'b0;
        end
        ST_WR_PULSE: if (cnt_zero) begin
          state_q     <= ST_WR_HOLD;
          sram_we_n_o <= 1'b1;
        end
        ST_WR_HOLD: begin
          state_q      <= ST_IDLE;
          sram_ce_n_o  <= 1'b1;
          sram_dq_oe_o <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          sram_ce_n_o,
  input logic          sram_oe_n_o,
  input logic          sram_we_n_o,
  input logic [AW-1:0] sram_addr_o,
  input logic [DW-1:0] sram_dq_o,
  input logic          sram_dq_oe_o
);
  a_r2_idle_pins: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |-> (sram_ce_n_o && sram_oe_n_o && sram_we_n_o && !sram_dq_oe_o));

  a_r4_strobe_in_window: assert property (@(posedge clk_i) disable iff (rst_i)
    !sram_we_n_o |-> (!sram_ce_n_o && sram_oe_n_o && sram_dq_oe_o));

  a_r5_stable_under_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
    !sram_we_n_o |-> ($stable(sram_addr_o) && $stable(sram_dq_o)));

  a_r5_hold_after_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sram_we_n_o) |-> (sram_dq_oe_o && !sram_ce_n_o && $stable(sram_dq_o)));

  a_r6_no_contention: assert property (@(posedge clk_i) disable iff (rst_i)
    !(sram_dq_oe_o && !sram_ce_n_o && !sram_oe_n_o && sram_we_n_o));

  a_r7_drive_after_release: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sram_dq_oe_o) |-> $past(sram_oe_n_o));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .busy_o(busy_o), .done_o(done_o),
  .sram_ce_n_o(sram_ce_n_o), .sram_oe_n_o(sram_oe_n_o),
  .sram_we_n_o(sram_we_n_o), .sram_addr_o(sram_addr_o),
  .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;
  localparam int CLK_NS = 8;
  localparam int T_AA   = 10;
  localparam int T_PWE  = 7;
  localparam int T_HZOE = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done;
  logic [7:0]  rdata;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [14:0] maddr;
  logic [7:0]  dq_o, dq_i, mem_out;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  asram_ctrl dut_i (
    .clk_i(clk), .rst_i(rst), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .sram_ce_n_o(ce_n), .sram_oe_n_o(oe_n), .sram_we_n_o(we_n),
    .sram_addr_o(maddr), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe),
    .sram_dq_i(dq_i)
  );

  // ---------------- behavioural memory ----------------
  logic [7:0] mem [int];
  logic       rd_valid = 1'b0;
  int         rd_k = 0, wr_k = 0;
  logic       prev_ovl = 1'b0;
  logic [7:0] wr_d;
  int         wr_a;
  longint     last_drv_t = -1000;

  function automatic logic [7:0] mrd(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  wire mem_drive = !ce_n && !oe_n && we_n;
  always_comb mem_out = rd_valid ? mrd(int'(maddr)) : ~mrd(int'(maddr));
  assign dq_i = mem_drive ? mem_out : (dq_oe ? dq_o : 8'h00);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_drive) begin
        rd_k++;
        rd_valid   <= (rd_k * CLK_NS - CLK_NS / 2) >= T_AA;
        last_drv_t = $time;
      end else begin
        rd_k = 0;
        rd_valid <= 1'b0;
      end
      if (dq_oe && mem_drive) chk(1'b0, "R6 bus overlap", 1, 0);
      if (dq_oe && ($time - last_drv_t) < (CLK_NS + T_HZOE))
        chk(1'b0, "R7 drive before release", int'($time - last_drv_t), CLK_NS + T_HZOE);
      if (!ce_n && !we_n) begin
        wr_k++;
        wr_d = dq_oe ? dq_o : 8'hxx;
        wr_a = int'(maddr);
        if (!dq_oe) chk(1'b0, "R4 data not driven in strobe", 0, 1);
        prev_ovl <= 1'b1;
      end else if (prev_ovl) begin
        chk(wr_k * CLK_NS >= T_PWE, "R4 strobe width", wr_k * CLK_NS, T_PWE);
        chk(dq_oe && dq_o == wr_d, "R5 data hold", int'(dq_o), int'(wr_d));
        mem[wr_a] = wr_d;
        wr_k = 0;
        prev_ovl <= 1'b0;
      end
    end
  end

  // ---------------- host side ----------------
  int n_ce, n_oe, n_we;
  logic [7:0] sb [int];

  task automatic host_op(input logic we, input logic [14:0] a, input logic [7:0] d,
                         output logic [7:0] rd, output int lat);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    n_ce = 0; n_oe = 0; n_we = 0;
    @(negedge clk);
    req = 1'b0; req_we = ~we; req_addr = ~a; req_wdata = ~d;
    lat = 1;
    n_ce += int'(!ce_n); n_oe += int'(!oe_n); n_we += int'(!we_n);
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      n_ce += int'(!ce_n); n_oe += int'(!oe_n); n_we += int'(!we_n);
    end
    rd = rdata;
    @(negedge clk);
    chk(!done, "R8 done one cycle", int'(done), 0);
    chk(ce_n && oe_n && we_n && !dq_oe, "R2 idle pins", {ce_n, oe_n, we_n, dq_oe}, 4'b1110);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(ce_n && oe_n && we_n && !dq_oe && !busy && !done, "R1 reset state",
        {ce_n, oe_n, we_n, dq_oe, busy, done}, 6'b111000);
    rst = 1'b0;
    @(negedge clk);
    chk(ce_n && oe_n && we_n && !dq_oe && !busy && !done, "R1 after reset",
        {ce_n, oe_n, we_n, dq_oe, busy, done}, 6'b111000);
  endtask

  task automatic t_write_then_read;
    logic [7:0] r; int lat;
    host_op(1'b1, 15'h0123, 8'hA5, r, lat);
    chk(lat == 4, "R8 store latency", lat, 4);
    chk(n_oe == 0, "R4 oe high in store", n_oe, 0);
    chk(n_we == 1, "R4 strobe cycles", n_we, 1);
    chk(n_ce == 3, "R5 ce window store", n_ce, 3);
    host_op(1'b0, 15'h0123, 8'h00, r, lat);
    chk(lat == 3, "R8 load latency", lat, 3);
    chk(n_ce == 2 && n_oe == 2 && n_we == 0, "R3 load pin window", n_ce * 16 + n_oe, 8'h22);
    chk(r == 8'hA5, "R3 R10 load data", r, 8'hA5);
  endtask

  task automatic t_boundaries;
    logic [7:0] r; int lat;
    host_op(1'b1, 15'h7FFF, 8'h3C, r, lat);
    host_op(1'b1, 15'h0000, 8'hC3, r, lat);
    host_op(1'b0, 15'h7FFF, 8'h00, r, lat);
    chk(r == 8'h3C, "R3 top address", r, 8'h3C);
    host_op(1'b1, 15'h0000, 8'h5A, r, lat);
    chk(lat == 5, "R7 load-to-store latency", lat, 5);
    chk(n_ce == 3, "R7 extra idle cycle", n_ce, 3);
    host_op(1'b0, 15'h0000, 8'h00, r, lat);
    chk(r == 8'h5A, "R3 bottom address", r, 8'h5A);
  endtask

  task automatic t_ignore_busy;
    logic [7:0] r; int lat;
    host_op(1'b1, 15'h0400, 8'h55, r, lat);
    @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 15'h0401; req_wdata = 8'h11;
    @(negedge clk);
    req_addr = 15'h0400; req_wdata = 8'hAA;
    @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
    host_op(1'b0, 15'h0400, 8'h00, r, lat);
    chk(r == 8'h55, "R9 busy request ignored", r, 8'h55);
    host_op(1'b0, 15'h0401, 8'h00, r, lat);
    chk(r == 8'h11, "R10 latched store data", r, 8'h11);
  endtask

  task automatic t_random;
    logic [7:0] r; int lat; int bad = 0;
    for (int i = 0; i < 16; i++) begin
      host_op(1'b1, 15'(16'h0200 + i), 8'(i * 7 + 3), r, lat);
      sb[i] = 8'(i * 7 + 3);
    end
    for (int i = 0; i < 80; i++) begin
      int a = int'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) begin
        logic [7:0] d = 8'($urandom);
        host_op(1'b1, 15'(16'h0200 + a), d, r, lat);
        sb[a] = d;
      end else begin
        host_op(1'b0, 15'(16'h0200 + a), 8'h00, r, lat);
        if (r != sb[a]) begin
          bad++;
          chk(1'b0, "R3 random load", r, sb[a]);
        end
      end
    end
    chk(bad == 0, "R3 random traffic", bad, 0);
  endtask

  initial begin
    t_reset();
    t_write_then_read();
    t_boundaries();
    t_ignore_busy();
    t_random();
    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule